// File: doc/BRIEF.md
# Compressed Pair Load/Store Expander

This stage sits in an RV32 fetch/decode path behind the compressed-instruction aligner. Each cycle it may receive one 16-bit instruction parcel. If the parcel is one of the four compressed doubleword register-pair forms, the stage rewrites it as the equivalent 32-bit pair load or pair store. The four forms are the register-based load and store and the stack-pointer-based load and store. The result is registered, so it appears one cycle after the parcel. The result comes with a valid flag, a claim flag and an illegal flag. When the claim flag is low, the parcel belongs to another expander. In that case the output word is zero.

The pair forms reuse the code points of the compressed single-precision float loads and stores. A parameter states whether that float feature is present. When it is present, this stage claims nothing. The stage also enforces the reserved encodings. A pair register must be even. The stack-pointer load may not name x0 as its destination. Either violation is reported through the illegal flag, and the output word is then forced to zero.

Top module: `cpx_pair_expander`

## Requirements
- R1: `exp_valid` equals `par_valid` one clock earlier. With `par_valid` low, the registered result has `exp_claim`, `exp_illegal` and `exp_word` all zero. After reset all outputs are zero.
- R2: The register-based load is a parcel with `[1:0]=00` and `[15:13]=011`. It expands to `{imm12, rs1, 3'b011, rd, 7'b0000011}`, where rd = 8+`[4:2]`, rs1 = 8+`[9:7]`, and imm12 is the zero-extended `{[6:5],[12:10],3'b000}`.
- R3: The register-based store is a parcel with `[1:0]=00` and `[15:13]=111`. It expands to `{imm12[11:5], rs2, rs1, 3'b011, imm12[4:0], 7'b0100011}`, where rs2 = 8+`[4:2]`, rs1 = 8+`[9:7]`, and the offset is built as in R2.
- R4: The stack-pointer load is a parcel with `[1:0]=10` and `[15:13]=011`. It expands to the pair load with base x2, rd = `[11:7]`, and imm12 the zero-extended `{[4:2],[12],[6:5],3'b000}`.
- R5: The stack-pointer store is a parcel with `[1:0]=10` and `[15:13]=111`. It expands to the pair store with base x2, rs2 = `[6:2]`, and imm12 the zero-extended `{[9:7],[12:10],3'b000}`. A source of x0 is legal.
- R6: A claimed parcel whose pair register (rd or rs2) is odd raises `exp_illegal`, and `exp_claim` stays high.
- R7: A stack-pointer load with rd = x0 raises `exp_illegal`.
- R8: Any other parcel is not claimed: `exp_claim` = 0, `exp_illegal` = 0 and `exp_word` = 0. This covers other quadrant/funct3 combinations and parcels with `[1:0]=11`.
- R9: With parameter `FLOAT_CMP_EN` = 1, no parcel is claimed.
- R10: Whenever a result is illegal or unclaimed, `exp_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_valid | input | 1 | A parcel is presented this cycle |
| par_instr | input | 16 | Compressed instruction parcel |
| exp_valid | output | 1 | Registered result is present |
| exp_claim | output | 1 | Parcel was one of the four pair forms |
| exp_illegal | output | 1 | Claimed parcel uses a reserved encoding |
| exp_word | output | 32 | Expanded 32-bit instruction, or zero |

## Verification
Every result is due exactly one rising edge after its parcel is presented. One register lies between the input and all four outputs.

The bench drives a parcel on a falling edge and samples the outputs on the next falling edge. This places each sample after the single capturing edge and away from it. A parcel is held for only one cycle, so each sample can belong to one parcel only.

The sweep covers every code point in the pair quadrants and checks each one against a reference computed in the bench from the requirement text. Directed tasks cover the reserved cases, foreign parcels, idle cycles and the variant with float present.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    localparam int OFFS_W   = 9;
    localparam int REG_W    = 5;
    localparam int WORD_W   = 32;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [2:0] F3_PAIR   = 3'b011;

    localparam logic [REG_W-1:0] SP_REG    = 5'd2;
    localparam logic [1:0]       PRIME_HI  = 2'b01;

    typedef enum logic [2:0] {
        K_NONE,
        K_LD,
        K_SD,
        K_LDSP,
        K_SDSP
    } pair_kind_e;

    typedef struct packed {
        logic              valid;
        logic              claim;
        logic              illegal;
        logic [WORD_W-1:0] word;
    } exp_res_t;

endpackage

// File: rtl/cpx_classify.sv
module cpx_classify
    import cpx_pkg::*;
#(
    parameter bit FLOAT_CMP_EN = 1'b0
) (
    input  logic [1:0]  quad,
    input  logic [2:0]  funct3,
    output pair_kind_e  kind
);

    generate
        if (FLOAT_CMP_EN) begin : g_float_owns
            assign kind = K_NONE;
        end else begin : g_pair_owns
            always_comb begin
                kind = K_NONE;
                unique case ({quad, funct3})
                    {2'b00, 3'b011}: kind = K_LD;
                    {2'b00, 3'b111}: kind = K_SD;
                    {2'b10, 3'b011}: kind = K_LDSP;
                    {2'b10, 3'b111}: kind = K_SDSP;
                    default:         kind = K_NONE;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/cpx_fields.sv
module cpx_fields
    import cpx_pkg::*;
(
    input  logic [12:2]       body,
    input  pair_kind_e        kind,
    output logic [REG_W-1:0]  pair_reg,
    output logic [REG_W-1:0]  base_reg,
    output logic [OFFS_W-1:0] offset
);

    always_comb begin
        pair_reg = '0;
        base_reg = '0;
        offset   = '0;
        unique case (kind)
            K_LD, K_SD: begin
                pair_reg = {PRIME_HI, body[4:2]};
                base_reg = {PRIME_HI, body[9:7]};
                offset   = {1'b0, body[6:5], body[12:10], 3'b000};
            end
            K_LDSP: begin
                pair_reg = body[11:7];
                base_reg = SP_REG;
                offset   = {body[4:2], body[12], body[6:5], 3'b000};
            end
            K_SDSP: begin
                pair_reg = body[6:2];
                base_reg = SP_REG;
                offset   = {body[9:7], body[12:10], 3'b000};
            end
            default: begin
                pair_reg = '0;
                base_reg = '0;
                offset   = '0;
            end
        endcase
    end

endmodule

// File: rtl/cpx_encode.sv
module cpx_encode
    import cpx_pkg::*;
(
    input  pair_kind_e        kind,
    input  logic [REG_W-1:0]  pair_reg,
    input  logic [REG_W-1:0]  base_reg,
    input  logic [OFFS_W-1:0] offset,
    output logic              claim,
    output logic              illegal,
    output logic [WORD_W-1:0] word
);

    localparam int IMM_W = 12;

    logic [IMM_W-1:0]  imm12;
    logic              is_store;
    logic              reserved;
    logic [WORD_W-1:0] raw;

    assign imm12    = {{(IMM_W-OFFS_W){1'b0}}, offset};
    assign is_store = (kind == K_SD) || (kind == K_SDSP);
    assign claim    = (kind != K_NONE);

    always_comb begin
        reserved = 1'b0;
        if (claim) begin
            reserved = pair_reg[0];
            if ((kind == K_LDSP) && (pair_reg == '0)) begin
                reserved = 1'b1;
            end
        end
    end

    always_comb begin
        if (is_store) begin
            raw = {imm12[11:5], pair_reg, base_reg, F3_PAIR, imm12[4:0], OPC_STORE};
        end else begin
            raw = {imm12, base_reg, F3_PAIR, pair_reg, OPC_LOAD};
        end
    end

    assign illegal = reserved;
    assign word    = (claim && !reserved) ? raw : '0;

endmodule

// File: rtl/cpx_pair_expander.sv
module cpx_pair_expander
    import cpx_pkg::*;
#(
    parameter bit FLOAT_CMP_EN = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        par_valid,
    input  logic [15:0] par_instr,
    output logic        exp_valid,
    output logic        exp_claim,
    output logic        exp_illegal,
    output logic [31:0] exp_word
);

    pair_kind_e        kind;
    logic [REG_W-1:0]  pair_reg;
    logic [REG_W-1:0]  base_reg;
    logic [OFFS_W-1:0] offset;
    logic              enc_claim;
    logic              enc_illegal;
    logic [WORD_W-1:0] enc_word;

    exp_res_t res_d, res_q;

    cpx_classify #(.FLOAT_CMP_EN(FLOAT_CMP_EN)) u_classify (
        .quad   (par_instr[1:0]),
        .funct3 (par_instr[15:13]),
        .kind   (kind)
    );

    cpx_fields u_fields (
        .body     (par_instr[12:2]),
        .kind     (kind),
        .pair_reg (pair_reg),
        .base_reg (base_reg),
        .offset   (offset)
    );

    cpx_encode u_encode (
        .kind     (kind),
        .pair_reg (pair_reg),
        .base_reg (base_reg),
        .offset   (offset),
        .claim    (enc_claim),
        .illegal  (enc_illegal),
        .word     (enc_word)
    );

    always_comb begin
        res_d = '0;
        if (par_valid) begin
            res_d.valid   = 1'b1;
            res_d.claim   = enc_claim;
            res_d.illegal = enc_illegal;
            res_d.word    = enc_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign exp_valid   = res_q.valid;
    assign exp_claim   = res_q.claim;
    assign exp_illegal = res_q.illegal;
    assign exp_word    = res_q.word;

    // R1: one-cycle latency of the valid flag
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |=> exp_valid);

    // R1: an idle cycle produces an empty result
    assert_idle_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !par_valid |=> (!exp_valid && !exp_claim && !exp_illegal && exp_word == '0));

    // R6: illegal is raised only for a claimed parcel
    assert_illegal_needs_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exp_illegal |-> exp_claim);

    // R10: no word leaves the stage unless it is a legal expansion
    assert_dead_word_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(exp_claim && !exp_illegal) |-> (exp_word == '0));

    // R6: a legal expansion always names an even pair register and the pair funct3
    assert_even_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_claim && !exp_illegal) |->
            ((exp_word[14:12] == F3_PAIR) &&
             ((exp_word[6:0] == OPC_LOAD) ? !exp_word[7] : !exp_word[20])));

    // R7: a legal load based on x2 never targets x0
    assert_sp_load_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_claim && !exp_illegal && exp_word[6:0] == OPC_LOAD && exp_word[19:15] == SP_REG)
            |-> (exp_word[11:7] != 5'd0));

    // R9: the float-owned variant claims nothing
    assert_float_variant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (FLOAT_CMP_EN != 1'b0) |-> !exp_claim);

endmodule

// File: tb/sim_cpx_pair_expander.sv
`timescale 1ns/1ps
module sim_cpx_pair_expander;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        par_valid;
    logic [15:0] par_instr;

    logic        v0, c0, i0;
    logic [31:0] w0;
    logic        v1, c1, i1;
    logic [31:0] w1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    cpx_pair_expander #(.FLOAT_CMP_EN(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .par_valid(par_valid), .par_instr(par_instr),
        .exp_valid(v0), .exp_claim(c0), .exp_illegal(i0), .exp_word(w0)
    );

    cpx_pair_expander #(.FLOAT_CMP_EN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .par_valid(par_valid), .par_instr(par_instr),
        .exp_valid(v1), .exp_claim(c1), .exp_illegal(i1), .exp_word(w1)
    );

    // Reference: {valid, claim, illegal, word} built from the requirement text
    function automatic logic [34:0] ref_out(input logic [15:0] c, input bit vld, input bit fown);
        logic        claim, ill, st;
        logic [4:0]  r, b;
        logic [11:0] imm;
        logic [31:0] w;
        claim = 1'b0; ill = 1'b0; w = '0; r = '0; b = '0; imm = '0; st = 1'b0;
        if (vld && !fown && (c[1:0] == 2'b00 || c[1:0] == 2'b10) && c[14:13] == 2'b11) begin
            claim = 1'b1;
            st    = c[15];
            if (c[1:0] == 2'b00) begin
                r   = 5'd8 + {2'b00, c[4:2]};
                b   = 5'd8 + {2'b00, c[9:7]};
                imm = 12'(c[6:5]) * 12'd64 + 12'(c[12:10]) * 12'd8;
            end else begin
                b = 5'd2;
                if (st) begin
                    r   = c[6:2];
                    imm = 12'(c[9:7]) * 12'd64 + 12'(c[12:10]) * 12'd8;
                end else begin
                    r   = c[11:7];
                    imm = 12'(c[4:2]) * 12'd64 + 12'(c[12]) * 12'd32 + 12'(c[6:5]) * 12'd8;
                end
            end
            ill = r[0] || (!st && c[1:0] == 2'b10 && r == 5'd0);
            if (!ill) begin
                w = st ? {imm[11:5], r, b, 3'b011, imm[4:0], 7'b0100011}
                       : {imm, b, 3'b011, r, 7'b0000011};
            end
        end
        return {vld ? 1'b1 : 1'b0, claim, ill, w};
    endfunction

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one parcel for one cycle, then sample after the capturing edge
    task automatic apply(input bit vld, input logic [15:0] c);
        @(negedge clk);
        par_valid = vld;
        par_instr = c;
        @(negedge clk);
        par_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; par_valid = 1'b0; par_instr = 16'h0000;
        repeat (3) @(negedge clk);
        check("R1 reset", {v0, c0, i0, w0}, 35'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_ld;
        // rd'=x10, rs1'=x9, offset 248
        apply(1'b1, 16'h7CE8);
        check("R2 ld", {v0, c0, i0, w0},
              {3'b110, 12'h0F8, 5'd9, 3'b011, 5'd10, 7'b0000011});
    endtask

    task automatic t_sd;
        // rs2'=x12, rs1'=x8, offset 8*1 + 64*2 = 136
        logic [15:0] c;
        logic [11:0] imm;
        c   = {3'b111, 3'b001, 3'b000, 2'b10, 3'b100, 2'b00};
        imm = 12'd136;
        apply(1'b1, c);
        check("R3 sd", {v0, c0, i0, w0},
              {3'b110, imm[11:5], 5'd12, 5'd8, 3'b011, imm[4:0], 7'b0100011});
    endtask

    task automatic t_ldsp;
        // rd=x20, offset 8*3 + 32 + 64*5 = 376
        logic [15:0] c;
        logic [11:0] imm;
        c   = {3'b011, 1'b1, 5'd20, 2'b11, 3'b101, 2'b10};
        imm = 12'd376;
        apply(1'b1, c);
        check("R4 ldsp", {v0, c0, i0, w0},
              {3'b110, imm, 5'd2, 3'b011, 5'd20, 7'b0000011});
    endtask

    task automatic t_sdsp_x0;
        // rs2=x0, offset 8*7 + 64*7 = 504
        logic [15:0] c;
        logic [11:0] imm;
        c   = {3'b111, 3'b111, 3'b111, 5'd0, 2'b10};
        imm = 12'd504;
        apply(1'b1, c);
        check("R5 sdsp x0", {v0, c0, i0, w0},
              {3'b110, imm[11:5], 5'd0, 5'd2, 3'b011, imm[4:0], 7'b0100011});
    endtask

    task automatic t_odd;
        apply(1'b1, {3'b011, 3'b000, 3'b000, 2'b00, 3'b001, 2'b00});   // rd'=x9
        check("R6 odd ld", {v0, c0, i0, w0}, {3'b111, 32'd0});
        apply(1'b1, {3'b111, 3'b000, 3'b000, 5'd7, 2'b10});            // rs2=x7
        check("R6 odd sdsp", {v0, c0, i0, w0}, {3'b111, 32'd0});
        check("R10 odd word", {32'd0, 3'd0}, {w0, 3'd0});
    endtask

    task automatic t_ldsp_x0;
        apply(1'b1, {3'b011, 1'b0, 5'd0, 2'b01, 3'b000, 2'b10});
        check("R7 ldsp x0", {v0, c0, i0, w0}, {3'b111, 32'd0});
    endtask

    task automatic t_foreign;
        apply(1'b1, 16'h4501);   // quadrant 1
        check("R8 quad1", {v0, c0, i0, w0}, {3'b100, 32'd0});
        apply(1'b1, 16'h6503);   // 32-bit low bits
        check("R8 wide", {v0, c0, i0, w0}, {3'b100, 32'd0});
        apply(1'b1, 16'h4508);   // quadrant 0, funct3 010
        check("R8 q0 f3", {v0, c0, i0, w0}, {3'b100, 32'd0});
    endtask

    task automatic t_idle;
        apply(1'b0, 16'h7CE8);
        check("R1 idle", {v0, c0, i0, w0}, 35'd0);
    endtask

    task automatic t_float;
        apply(1'b1, 16'h7CE8);
        check("R9 float ld", {v1, c1, i1, w1}, {3'b100, 32'd0});
        apply(1'b1, {3'b011, 1'b0, 5'd0, 2'b01, 3'b000, 2'b10});
        check("R9 float ldsp", {v1, c1, i1, w1}, {3'b100, 32'd0});
    endtask

    task automatic t_sweep;
        for (int q = 0; q < 2; q++) begin
            for (int f = 0; f < 2; f++) begin
                for (int b = 0; b < 2048; b++) begin
                    logic [15:0] c;
                    logic [34:0] e;
                    string tag;
                    c = {(f != 0) ? 3'b111 : 3'b011, 11'(b), (q != 0) ? 2'b10 : 2'b00};
                    apply(1'b1, c);
                    e = ref_out(c, 1'b1, 1'b0);
                    if (e[32])       tag = (q != 0 && f == 0 && c[11:7] == 5'd0) ? "R7 sweep" : "R6 sweep";
                    else if (q == 0) tag = (f != 0) ? "R3 sweep" : "R2 sweep";
                    else             tag = (f != 0) ? "R5 sweep" : "R4 sweep";
                    check(tag, {v0, c0, i0, w0}, e);
                    if (e[32]) check("R10 sweep", {3'd0, w0}, 35'd0);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_ld;
        t_sd;
        t_ldsp;
        t_sdsp_x0;
        t_odd;
        t_ldsp_x0;
        t_foreign;
        t_idle;
        t_float;
        t_sweep;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule